// File: doc/BRIEF.md
# LCD Common Timing Generator

This block produces the row-scan timing for a multiplexed passive LCD driver. A one-cycle line pulse steps a line counter, one of sixteen common outputs is raised for the current row, and a frame-polarity signal flips once per complete frame so that the panel sees an AC drive that alternates frame by frame.

The scan depth is chosen by a command: a short scan of 16 rows or a long scan of 32 rows. A new choice is held pending and only takes effect at the next frame boundary, so no frame is ever cut short. For the long scan two identical chips work as a pair. The chip strapped as master counts the frame, drives the polarity signal and lights its commons for rows 0 to 15. The chip strapped as slave takes the master's polarity signal as an input, forces its counter back to row 0 whenever that signal changes, and lights its commons for rows 16 to 31. The line pulse, the command and the polarity signal are all synchronous to `clk`.

The scan is a two-state machine. `SCAN_LOWER` covers rows 0 to 15 and `SCAN_UPPER` covers rows 16 to 31. Transitions: *advance* (line pulse below the last row of a half, stay and count up), *split* (line pulse at row 15 with the long scan applied, go from `SCAN_LOWER` to `SCAN_UPPER`), *wrap* (line pulse at the last row of the frame, return to `SCAN_LOWER` at row 0; this is the frame end), and *lock* (slave only: the incoming polarity differs from the one last captured, go to `SCAN_LOWER` at row 0 from either state).

Top module: `lcd_com_timing`

## Requirements
- R1: While reset is asserted and right after it, `line_idx` is 0, `frame_out` is 0, `duty32_now` is 0 (16-row scan), a master has only `com_active[0]` high and a slave has all commons low.
- R2: With the 16-row scan applied, each line pulse moves a master's `line_idx` up by one at the next clock edge; after row 15 it returns to 0, and `com_active` has exactly bit `line_idx` set.
- R3: A master inverts `frame_out` at the clock edge where the scan wraps back to row 0 and holds it at every other edge, so it flips once per frame.
- R4: With the 32-row scan applied, a master counts rows 0 to 31 before wrapping; it sets bit `line_idx` of `com_active` on rows 0 to 15 and keeps all commons low on rows 16 to 31.
- R5: A slave sets bit `line_idx - 16` of `com_active` on rows 16 to 31 and keeps all commons low on rows 0 to 15; with the 16-row scan applied a slave keeps all commons low.
- R6: In a slave, the first clock edge at which `frame_in` differs from the value last captured sets `line_idx` to 0, whatever row it was on.
- R7: A duty command (`duty_wr` high, `duty_sel` 1 for 32 rows, 0 for 16 rows) does not change the current frame; the new scan length, and `duty32_now`, take effect at the following wrap (or lock on a slave).
- R8: In cycles without a line pulse (and, on a slave, without a polarity change), `line_idx` and `com_active` hold their values.
- R9: A slave presents on `frame_out` the value `frame_in` had one clock edge earlier.
- R10: At most one bit of `com_active` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse per line period |
| duty_wr | input | 1 | Strobe that records a duty command |
| duty_sel | input | 1 | Duty command value: 1 = 32 rows, 0 = 16 rows |
| is_slave | input | 1 | Role strap: 0 master or single chip, 1 slave |
| frame_in | input | 1 | Polarity from the master (used by a slave) |
| frame_out | output | 1 | Frame polarity (generated by a master, echoed by a slave) |
| com_active | output | ROWS (16) | One-hot active common of this chip |
| line_idx | output | $clog2(ROWS)+1 (5) | Current row of the whole scan |
| duty32_now | output | 1 | Scan length in effect: 1 = 32 rows |

## Verification
Every result here is registered once: a line pulse, a duty boundary or a polarity change seen before a rising edge shows on `line_idx`, `com_active` and `frame_out` right after that edge, and a slave's `frame_out` echoes `frame_in` one edge later. The bench drives each stimulus on a falling edge, pushes the values it expects for the following rising edge into a queue, and a monitor pops and compares them one time unit after that rising edge, so every comparison lands in the cycle the result is due. Line pulses are separated by an idle cycle so that a slave following a real master receives the polarity change between pulses, and the lock case is exercised by driving the slave's polarity input directly.

// File: rtl/lcd_ct_pkg.sv
package lcd_ct_pkg;

    // Which half of the full scan the row counter is in
    typedef enum logic {
        SCAN_LOWER = 1'b0,
        SCAN_UPPER = 1'b1
    } scan_state_e;

endpackage

// File: rtl/lcd_ct_duty_reg.sv
// Holds the commanded scan length and moves it into effect at frame ends.
module lcd_ct_duty_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_long,
    input  logic frame_end,
    output logic long_applied
);

    logic long_pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_pending <= 1'b0;
        end else if (cmd_wr) begin
            long_pending <= cmd_long;
        end
    end

    // A command written in the boundary cycle itself waits for the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_applied <= 1'b0;
        end else if (frame_end) begin
            long_applied <= long_pending;
        end
    end

endmodule

// File: rtl/lcd_ct_scan_fsm.sv
// Row counter split into two halves, frame polarity and slave lock.
module lcd_ct_scan_fsm
    import lcd_ct_pkg::*;
#(
    parameter int ROWS  = 16,
    localparam int SUB_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             slave,
    input  logic             pol_in,
    input  logic             long_scan,
    output scan_state_e      state,
    output logic [SUB_W-1:0] sub,
    output logic             pol,
    output logic             frame_end
);

    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(ROWS - 1);

    scan_state_e      state_nx;
    logic [SUB_W-1:0] sub_nx;
    logic             wrap;
    logic             lock;
    logic             at_last;

    assign at_last = (sub == SUB_LAST);
    assign lock    = slave && (pol_in != pol);

    // Next-state process
    always_comb begin
        state_nx = state;
        sub_nx   = sub;
        wrap     = 1'b0;
        unique case (state)
            SCAN_LOWER: begin
                if (lock) begin
                    state_nx = SCAN_LOWER;
                    sub_nx   = '0;
                end else if (tick && at_last) begin
                    sub_nx = '0;
                    if (long_scan) begin
                        state_nx = SCAN_UPPER;
                    end else begin
                        state_nx = SCAN_LOWER;
                        wrap     = 1'b1;
                    end
                end else if (tick) begin
                    sub_nx = sub + 1'b1;
                end
            end
            SCAN_UPPER: begin
                if (lock) begin
                    state_nx = SCAN_LOWER;
                    sub_nx   = '0;
                end else if (tick && at_last) begin
                    state_nx = SCAN_LOWER;
                    sub_nx   = '0;
                    wrap     = 1'b1;
                end else if (tick) begin
                    sub_nx = sub + 1'b1;
                end
            end
            default: begin
                state_nx = SCAN_LOWER;
                sub_nx   = '0;
            end
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SCAN_LOWER;
            sub   <= '0;
        end else begin
            state <= state_nx;
            sub   <= sub_nx;
        end
    end

    // Polarity: generated by a master, captured from the input by a slave
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol <= 1'b0;
        end else if (slave) begin
            pol <= pol_in;
        end else if (wrap) begin
            pol <= ~pol;
        end
    end

    assign frame_end = wrap || lock;

endmodule

// File: rtl/lcd_ct_com_decode.sv
// Turns the row within a half into this chip's one-hot common drive.
module lcd_ct_com_decode
    import lcd_ct_pkg::*;
#(
    parameter int ROWS  = 16,
    localparam int SUB_W = $clog2(ROWS)
) (
    input  scan_state_e      state,
    input  logic [SUB_W-1:0] sub,
    input  logic             slave,
    output logic [ROWS-1:0]  com
);

    logic own_half;

    // Master owns the lower half, slave the upper half
    assign own_half = slave ? (state == SCAN_UPPER) : (state == SCAN_LOWER);

    for (genvar g = 0; g < ROWS; g++) begin : g_com
        assign com[g] = own_half && (sub == SUB_W'(g));
    end

endmodule

// File: rtl/lcd_com_timing.sv
module lcd_com_timing
    import lcd_ct_pkg::*;
#(
    parameter int ROWS  = 16,
    localparam int SUB_W = $clog2(ROWS),
    localparam int LW    = SUB_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_tick,
    input  logic            duty_wr,
    input  logic            duty_sel,
    input  logic            is_slave,
    input  logic            frame_in,
    output logic            frame_out,
    output logic [ROWS-1:0] com_active,
    output logic [LW-1:0]   line_idx,
    output logic            duty32_now
);

    scan_state_e      state;
    logic [SUB_W-1:0] sub;
    logic             frame_end;

    lcd_ct_duty_reg u_duty (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (duty_wr),
        .cmd_long     (duty_sel),
        .frame_end    (frame_end),
        .long_applied (duty32_now)
    );

    lcd_ct_scan_fsm #(.ROWS(ROWS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (line_tick),
        .slave     (is_slave),
        .pol_in    (frame_in),
        .long_scan (duty32_now),
        .state     (state),
        .sub       (sub),
        .pol       (frame_out),
        .frame_end (frame_end)
    );

    lcd_ct_com_decode #(.ROWS(ROWS)) u_dec (
        .state (state),
        .sub   (sub),
        .slave (is_slave),
        .com   (com_active)
    );

    assign line_idx = {(state == SCAN_UPPER), sub};

endmodule

// File: rtl/lcd_com_timing_chk.sv
module lcd_com_timing_chk #(
    parameter int ROWS  = 16,
    localparam int SUB_W = $clog2(ROWS),
    localparam int LW    = SUB_W + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            line_tick,
    input logic            is_slave,
    input logic            frame_in,
    input logic            frame_out,
    input logic [ROWS-1:0] com_active,
    input logic [LW-1:0]   line_idx
);

    // R10
    onehot_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_active));

    // R3
    master_flip_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_slave && !$stable(frame_out)) |-> (line_idx == '0));

    // R2
    master_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_slave && line_tick && (line_idx[SUB_W-1:0] != SUB_W'(ROWS - 1)))
        |=> (line_idx == $past(line_idx) + 1'b1));

    // R8
    master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_slave && !line_tick) |=> ($stable(line_idx) && $stable(com_active)));

    // R6
    slave_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_slave && (frame_in != frame_out)) |=> (line_idx == '0));

    // R9
    slave_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_slave |=> (frame_out == $past(frame_in)));

    // R5
    slave_upper_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_slave && (|com_active)) |-> line_idx[LW-1]);

endmodule

bind lcd_com_timing lcd_com_timing_chk #(.ROWS(ROWS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_tick  (line_tick),
    .is_slave   (is_slave),
    .frame_in   (frame_in),
    .frame_out  (frame_out),
    .com_active (com_active),
    .line_idx   (line_idx)
);

// File: tb/lcd_com_timing_tb.sv
module lcd_com_timing_tb;

    localparam int ROWS = 16;
    localparam int LW   = $clog2(ROWS) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 1'b0;
    logic duty_wr = 1'b0;
    logic duty_sel = 1'b0;
    logic fsel = 1'b0;
    logic fdrv = 1'b0;

    logic            m_frame, s_frame, s_fin, m_d32, s_d32;
    logic [ROWS-1:0] m_com, s_com;
    logic [LW-1:0]   m_line, s_line;

    always #5 clk = ~clk;

    assign s_fin = fsel ? fdrv : m_frame;

    lcd_com_timing #(.ROWS(ROWS)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .duty_wr(duty_wr),
        .duty_sel(duty_sel), .is_slave(1'b0), .frame_in(1'b0),
        .frame_out(m_frame), .com_active(m_com), .line_idx(m_line),
        .duty32_now(m_d32)
    );

    lcd_com_timing #(.ROWS(ROWS)) u_slv (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .duty_wr(duty_wr),
        .duty_sel(duty_sel), .is_slave(1'b1), .frame_in(s_fin),
        .frame_out(s_frame), .com_active(s_com), .line_idx(s_line),
        .duty32_now(s_d32)
    );

    typedef struct {
        string           tag;
        int              line;
        logic [ROWS-1:0] mcom;
        logic [ROWS-1:0] scom;
        logic            mframe;
        logic            sframe;
        logic            d32;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model of the requirements
    int   ml = 0;
    logic mframe = 1'b0;
    logic mduty = 1'b0;
    logic mpend = 1'b0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [ROWS-1:0] onehot(input int k);
        return ROWS'(1) << k;
    endfunction

    // Driver: one cycle of stimulus, expectation for the coming edge
    task automatic step(input string tag, input logic tk, input logic wr, input logic d);
        exp_t e;
        logic old_frame;
        @(negedge clk);
        line_tick = tk;
        duty_wr   = wr;
        duty_sel  = d;
        old_frame = mframe;
        if (tk) begin
            if (ml == (mduty ? 2*ROWS-1 : ROWS-1)) begin
                ml     = 0;
                mframe = ~mframe;
                mduty  = mpend;
            end else begin
                ml++;
            end
        end
        if (wr) mpend = d;
        e.tag    = tag;
        e.line   = ml;
        e.mcom   = (ml < ROWS) ? onehot(ml) : '0;
        e.scom   = (mduty && ml >= ROWS) ? onehot(ml - ROWS) : '0;
        e.mframe = mframe;
        e.sframe = old_frame;
        e.d32    = mduty;
        exp_q.push_back(e);
    endtask

    task automatic line(input string tag, input logic wr = 1'b0, input logic d = 1'b0);
        step(tag, 1'b1, wr, d);
        step(tag, 1'b0, 1'b0, 1'b0);
    endtask

    // Monitor: compares one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "master line_idx", int'(m_line), e.line);
                check(e.tag, "master com_active", int'(m_com), int'(e.mcom));
                check("R3", "master frame_out", int'(m_frame), int'(e.mframe));
                check("R7", "master duty32_now", int'(m_d32), int'(e.d32));
                check("R5", "slave line_idx", int'(s_line), e.line);
                check("R5", "slave com_active", int'(s_com), int'(e.scom));
                check("R9", "slave frame_out", int'(s_frame), int'(e.sframe));
                check("R10", "one-hot commons", int'($countones(m_com) <= 1 && $countones(s_com) <= 1), 1);
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "master line_idx", int'(m_line), 0);
        check("R1", "master com_active", int'(m_com), 1);
        check("R1", "master frame_out", int'(m_frame), 0);
        check("R1", "duty32_now", int'(m_d32), 0);
        check("R1", "slave com_active", int'(s_com), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: 16-row scan, two full frames and a bit
        for (int i = 0; i < 36; i++) line("R2");

        // R7: ask for 32 rows mid-frame; current frame still wraps at 15
        line("R7", 1'b1, 1'b1);
        for (int i = 0; i < 14; i++) line("R7");

        // R4: 32-row frames, master lower half, slave upper half
        for (int i = 0; i < 70; i++) line("R4");

        // R8: no line pulses, everything holds
        for (int i = 0; i < 6; i++) step("R8", 1'b0, 1'b0, 1'b0);

        // back to 16 rows at the next boundary
        line("R7", 1'b1, 1'b0);
        while (!(ml == 0 && !mduty)) line("R7");
        for (int i = 0; i < 18; i++) line("R2");

        // R6: lock of the slave by a directly driven polarity change
        line("R6", 1'b1, 1'b1);
        while (ml != 0) line("R6");
        for (int i = 0; i < 20; i++) line("R6");
        repeat (3) @(posedge clk);
        @(negedge clk);
        fdrv = m_frame;
        fsel = 1'b1;
        @(posedge clk);
        #1;
        check("R6", "slave line before lock", int'(s_line), 20);
        @(negedge clk);
        fdrv = ~fdrv;
        @(posedge clk);
        #1;
        check("R6", "slave line after lock", int'(s_line), 0);
        check("R5", "slave commons on row 0", int'(s_com), 0);
        check("R9", "slave frame echo", int'(s_frame), int'(fdrv));
        check("R4", "master unaffected", int'(m_line), 20);

        repeat (2) @(posedge clk);
        report();
    end

endmodule